// File: doc/BRIEF.md
# Upstream AIS Indication Detector

This block decides whether the upstream section is signalling an alarm (AIS) condition, and turns that decision into requests for a downstream line AIS and a transmit path RDI. It takes its evidence from one of two sources, chosen by a select bit.

The first source is the orderwire-position overhead byte. The block samples this byte once per frame, when a frame strobe marks it, and takes a majority vote over its eight bits. The second source is two external status leads. Each lead is synchronised to the block clock before use.

Whichever source is active, its alarm flags are always reported. Two enable bits decide whether an active condition is passed on as a line-AIS request and as an RDI request.

Top module: `upstream_ais_det`

## Requirements
- R1: After reset, and before any frame strobe or lead activity, all five outputs are 0.
- R2: With `src_ext` = 0, a strobed byte that has five or more bits set to 1 sets `e1_alarm` in the cycle after the strobe. This holds even when the alarm was clear before, so one frame is enough.
- R3: With `src_ext` = 0, a strobed byte that has four or fewer bits set to 1 clears `e1_alarm` in the cycle after the strobe. This holds even when the alarm was set before.
- R4: Between frame strobes, `e1_alarm` keeps its value. Changes on `e1_byte` without a strobe have no effect.
- R5: With `src_ext` = 1, `e1_alarm` is 0 one cycle later and stays 0, even when strobed bytes are all ones.
- R6: With `src_ext` = 1, `stat_alarm` follows `stat_in` and `pais_alarm` follows `pais_in`, each after two clock edges of synchronisation.
- R7: With `src_ext` = 0, `stat_alarm` and `pais_alarm` are 0 whatever the leads hold.
- R8: `line_ais_req` is 1 exactly when `line_ais_en` is 1 and at least one of the three alarm flags is 1.
- R9: `rdi_req` is 1 exactly when `rdi_en` is 1 and at least one of the three alarm flags is 1.
- R10: The alarm flags do not depend on `line_ais_en` or `rdi_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse marking a valid `e1_byte` |
| e1_byte | input | 8 | Overhead byte used for the majority vote |
| stat_in | input | 1 | External upstream status lead, active high |
| pais_in | input | 1 | External upstream path AIS lead, active high |
| src_ext | input | 1 | Source select: 0 = overhead byte, 1 = external leads |
| line_ais_en | input | 1 | Enables the line-AIS request |
| rdi_en | input | 1 | Enables the path RDI request |
| e1_alarm | output | 1 | AIS detected in the overhead byte |
| stat_alarm | output | 1 | Synchronised status lead alarm |
| pais_alarm | output | 1 | Synchronised path AIS lead alarm |
| line_ais_req | output | 1 | Request for a downstream line AIS |
| rdi_req | output | 1 | Request for a transmit path RDI |

## Verification
The hardest cases to reach are at the majority threshold, where four and five ones sit side by side. The bench walks all 256 byte values in order. Because of that order, each value is strobed while the alarm is in whatever state the previous value left it, so entry and exit from both starting states occur many times.

Source switching while the alarm is set is driven directly. The bench first sets the alarm with an all-ones byte, flips the select bit, and then keeps strobing all-ones bytes.

// File: rtl/upstream_ais_det.sv
module upstream_ais_det #(
  parameter int BYTE_W      = 8,
  parameter int MAJ_THRESH  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic [BYTE_W-1:0] e1_byte,
  input  logic              stat_in,
  input  logic              pais_in,
  input  logic              src_ext,
  input  logic              line_ais_en,
  input  logic              rdi_en,
  output logic              e1_alarm,
  output logic              stat_alarm,
  output logic              pais_alarm,
  output logic              line_ais_req,
  output logic              rdi_req
);
  localparam int CW = $clog2(BYTE_W + 1);

  function automatic logic [CW-1:0] ones(input logic [BYTE_W-1:0] b);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + CW'(b[i]);
    return n;
  endfunction

  logic vote;
  assign vote = ones(e1_byte) >= CW'(MAJ_THRESH);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            e1_alarm <= 1'b0;
    else if (src_ext)      e1_alarm <= 1'b0;
    else if (frame_strobe) e1_alarm <= vote;

  logic [SYNC_STAGES-1:0] stat_sync, pais_sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_sync <= '0;
      pais_sync <= '0;
    end else begin
      stat_sync <= {stat_sync[SYNC_STAGES-2:0], stat_in};
      pais_sync <= {pais_sync[SYNC_STAGES-2:0], pais_in};
    end

  assign stat_alarm = src_ext & stat_sync[SYNC_STAGES-1];
  assign pais_alarm = src_ext & pais_sync[SYNC_STAGES-1];

  logic upstream;
  assign upstream     = e1_alarm | stat_alarm | pais_alarm;
  assign line_ais_req = upstream & line_ais_en;
  assign rdi_req      = upstream & rdi_en;

  // R2
  enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !src_ext && $countones(e1_byte) >= MAJ_THRESH) |=> e1_alarm);
  // R3
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !src_ext && $countones(e1_byte) < MAJ_THRESH) |=> !e1_alarm);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_strobe && !src_ext) |=> $stable(e1_alarm));
  // R5
  ext_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ext |=> !e1_alarm);
  // R7
  lead_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ext |-> !(stat_alarm || pais_alarm));
  // R8
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_ais_req |-> (line_ais_en && (e1_alarm || stat_alarm || pais_alarm)));
  // R9
  rdi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdi_req |-> (rdi_en && (e1_alarm || stat_alarm || pais_alarm)));
endmodule

// File: tb/upstream_ais_det_test.sv
module upstream_ais_det_test;
  logic clk = 0, rst_n = 0;
  logic frame_strobe = 0, stat_in = 0, pais_in = 0, src_ext = 0;
  logic line_ais_en = 0, rdi_en = 0;
  logic [7:0] e1_byte = 0;
  logic e1_alarm, stat_alarm, pais_alarm, line_ais_req, rdi_req;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  upstream_ais_det uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk) begin e1_byte = b; frame_strobe = 1; end
    @(negedge clk) frame_strobe = 0;
  endtask

  function automatic int pop(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return n;
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 e1", e1_alarm, 0);
    chk("R1 stat", stat_alarm, 0);
    chk("R1 pais", pais_alarm, 0);
    chk("R1 line", line_ais_req, 0);
    chk("R1 rdi", rdi_req, 0);

    // R2 R3 R4 R8 R9 R10: all bytes, enables cycle through all four combinations
    for (int v = 0; v < 256; v++) begin
      logic exp;
      line_ais_en = v[0];
      rdi_en = v[1];
      exp = pop(v[7:0]) >= 5;
      strobe(v[7:0]);
      chk(exp ? "R2 enter" : "R3 exit", e1_alarm, exp);
      chk("R8 line", line_ais_req, exp & v[0]);
      chk("R9 rdi", rdi_req, exp & v[1]);
      e1_byte = ~v[7:0];
      @(negedge clk);
      chk("R4 hold", e1_alarm, exp);
    end

    // R5
    strobe(8'hFF);
    chk("R2 set before switch", e1_alarm, 1);
    src_ext = 1;
    @(negedge clk);
    chk("R5 cleared", e1_alarm, 0);
    for (int k = 0; k < 4; k++) begin
      strobe(8'hFF);
      chk("R5 ignored", e1_alarm, 0);
    end

    // R6 R7 R8 R9 R10: leads, select and enables
    for (int c = 0; c < 32; c++) begin
      logic ea, eb;
      @(negedge clk) begin
        stat_in = c[0]; pais_in = c[1]; src_ext = c[2];
        line_ais_en = c[3]; rdi_en = c[4];
      end
      @(negedge clk);
      ea = c[2] & c[0];
      eb = c[2] & c[1];
      if (c[2]) begin
        chk("R6 stat one edge", stat_alarm, 1'b0);
        chk("R6 pais one edge", pais_alarm, 1'b0);
      end
      @(negedge clk);
      @(negedge clk);
      chk(c[2] ? "R6 stat" : "R7 stat", stat_alarm, ea);
      chk(c[2] ? "R6 pais" : "R7 pais", pais_alarm, eb);
      chk("R8 line lead", line_ais_req, (ea | eb) & c[3]);
      chk("R9 rdi lead", rdi_req, (ea | eb) & c[4]);
      chk("R5 e1 off", e1_alarm, 0);
      @(negedge clk) begin stat_in = 0; pais_in = 0; end
      repeat (3) @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule